// File: doc/BRIEF.md
# Flash Program/Erase Status Register

This block holds the 8-bit status word of a flash command interface. A command decoder delivers single-cycle strobes for program, erase, suspend, resume and clear-status. The block checks each program or erase against a locked-block input, a programming-voltage fault input and any protection error left over from an earlier command. It then either aborts with an error flag or starts a stand-in program/erase engine. That engine stays busy for a fixed number of clock cycles. If a fault input is high on its last cycle, the operation ends in error.

Suspend requests are not honoured at once. A grant window of `GRANT_CYCLES` cycles opens first, and the engine keeps working through it. The operation is parked only if it is still running when the window closes. Otherwise it completes as usual and no suspend flag appears. Error flags are sticky, and one clear-status command drops them all.

The status word is read through a small valid/ready port. A request is taken whenever `rd_req_ready` is high, which is whenever the output slot is empty or is being drained in the same cycle. The captured word appears on `st_data` with `st_valid` one cycle later. It stays unchanged while `st_ready` is low. A request made while `rd_req_ready` is low is not taken and is not remembered. Each response shows the word as it stood in the cycle the request was taken, before any command strobed in that same cycle acts.

Top module: `pe_status_reg`

## Requirements
- R1: After reset, a status read returns 0x80, and `st_valid` is low until the first read is taken.
- R2: Bit 0 always reads 0. Bit 7 reads 0 while an operation is running and 1 otherwise. An accepted operation holds bit 7 at 0 for exactly `OP_CYCLES` consecutive cycles, starting the cycle after the command.
- R3: A suspend sampled while an operation runs is granted `GRANT_CYCLES` cycles later if the operation is still running at that point. On a grant, bit 7 returns to 1 and the suspend flag is set: bit 2 for a program, bit 6 for an erase.
- R4: If the operation's last cycle falls at or before the end of the grant window, no suspend flag is set. The operation completes after exactly `OP_CYCLES` busy cycles.
- R5: A resume clears the suspend flag and continues the operation for only the cycles it had left when it was parked.
- R6: Whenever bit 7 reads 0, bits 6 and 2 read 0.
- R7: A program or erase aimed at a locked block sets bit 1 and does not start the engine, so bit 7 stays 1.
- R8: Bit 1 stays 1 until clear-status or reset. While bit 1 is 1, a new program sets bit 4 and a new erase sets bit 5, and neither starts.
- R9: A program or erase issued during a voltage fault sets bit 3 and does not start.
- R10: If `op_fault` is high in the last running cycle, bit 4 is set for a program and bit 5 for an erase.
- R11: Bits 5, 4, 3 and 1 survive later successful operations. A single clear-status clears all four together.
- R12: A program or erase issued while an operation is running or suspended is ignored. The status word, including bit 1 under a locked block, stays the same, and the remaining duration is unchanged.
- R13: While `st_valid` is high and `st_ready` is low, `st_data` and `st_valid` hold and `rd_req_ready` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_prog | input | 1 | Program command strobe (wins over erase) |
| cmd_erase | input | 1 | Erase command strobe |
| cmd_suspend | input | 1 | Suspend command strobe |
| cmd_resume | input | 1 | Resume command strobe |
| cmd_clear | input | 1 | Clear-status command strobe |
| blk_locked | input | 1 | Target block of the current command is locked |
| vpp_fault | input | 1 | Programming voltage is out of range |
| op_fault | input | 1 | Engine reports failure when sampled on the last running cycle |
| rd_req_valid | input | 1 | Read-status request |
| rd_req_ready | output | 1 | Request can be taken this cycle |
| st_valid | output | 1 | Status response valid |
| st_ready | input | 1 | Consumer accepts the response |
| st_data | output | 8 | Status word |

## Verification
The hardest case to reach from the ports is a suspend that races the operation's own completion. Whether the flag appears depends on where the grant window ends relative to the last busy cycle. The bench therefore issues the suspend at every cycle of a short operation, for both program and erase. It reads status on every cycle to count the busy cycles before and after the resume, and compares the counts and final words with values computed from `OP_CYCLES` and `GRANT_CYCLES`. A second sweep walks all combinations of a leftover protection error, a locked block, a voltage fault and the operation kind.

// File: rtl/pe_status_pkg.sv
package pe_status_pkg;
  typedef enum logic [1:0] {
    ENG_IDLE = 2'd0,
    ENG_RUN  = 2'd1,
    ENG_SUSP = 2'd2
  } eng_state_e;

  // indices into the sticky error vector
  localparam int unsigned ERR_N    = 4;
  localparam int unsigned ERR_PROT = 0;
  localparam int unsigned ERR_VPP  = 1;
  localparam int unsigned ERR_PGM  = 2;
  localparam int unsigned ERR_ERS  = 3;
endpackage

// File: rtl/pe_op_engine.sv
module pe_op_engine
  import pe_status_pkg::*;
#(
  parameter int unsigned OP_CYCLES    = 2000,
  parameter int unsigned GRANT_CYCLES = 500
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic start_erase,
  input  logic suspend,
  input  logic resume,
  output logic idle,
  output logic running,
  output logic parked,
  output logic kind_erase,
  output logic finish
);
  localparam int unsigned CW = $clog2(OP_CYCLES + 1);
  localparam int unsigned GW = $clog2(GRANT_CYCLES + 1);

  eng_state_e      state_q;
  logic [CW-1:0]   rem_q;
  logic [GW-1:0]   win_q;
  logic            pend_q;
  logic            kind_q;

  assign idle       = (state_q == ENG_IDLE);
  assign running    = (state_q == ENG_RUN);
  assign parked     = (state_q == ENG_SUSP);
  assign kind_erase = kind_q;
  assign finish     = running && (rem_q == CW'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ENG_IDLE;
      rem_q   <= '0;
      win_q   <= '0;
      pend_q  <= 1'b0;
      kind_q  <= 1'b0;
    end else begin
      unique case (state_q)
        ENG_IDLE: begin
          if (start) begin
            state_q <= ENG_RUN;
            rem_q   <= CW'(OP_CYCLES);
            kind_q  <= start_erase;
            pend_q  <= 1'b0;
          end
        end
        ENG_RUN: begin
          if (finish) begin
            state_q <= ENG_IDLE;
            pend_q  <= 1'b0;
          end else begin
            rem_q <= rem_q - CW'(1);
            if (pend_q) begin
              if (win_q == GW'(1)) begin
                state_q <= ENG_SUSP;
                pend_q  <= 1'b0;
              end else begin
                win_q <= win_q - GW'(1);
              end
            end else if (suspend) begin
              pend_q <= 1'b1;
              win_q  <= GW'(GRANT_CYCLES);
            end
          end
        end
        ENG_SUSP: begin
          if (resume) state_q <= ENG_RUN;
        end
        default: state_q <= ENG_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pe_err_flags.sv
module pe_err_flags
  import pe_status_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic [ERR_N-1:0] set_v,
  output logic [ERR_N-1:0] flags
);
  for (genvar i = 0; i < ERR_N; i++) begin : g_flag
    logic bit_q;
    always_ff @(posedge clk) begin
      if (!rst_n) bit_q <= 1'b0;
      else        bit_q <= set_v[i] | (bit_q & ~clear);
    end
    assign flags[i] = bit_q;
  end
endmodule

// File: rtl/pe_read_port.sv
module pe_read_port #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         req_valid,
  output logic         req_ready,
  input  logic [W-1:0] word_in,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  assign req_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (req_valid && req_ready) begin
      out_valid <= 1'b1;
      out_data  <= word_in;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/pe_status_reg.sv
module pe_status_reg
  import pe_status_pkg::*;
#(
  parameter int unsigned OP_CYCLES    = 2000,
  parameter int unsigned GRANT_CYCLES = 500
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_prog,
  input  logic       cmd_erase,
  input  logic       cmd_suspend,
  input  logic       cmd_resume,
  input  logic       cmd_clear,
  input  logic       blk_locked,
  input  logic       vpp_fault,
  input  logic       op_fault,
  input  logic       rd_req_valid,
  output logic       rd_req_ready,
  output logic       st_valid,
  input  logic       st_ready,
  output logic [7:0] st_data
);
  logic             eng_idle, eng_running, eng_parked, eng_kind, eng_finish;
  logic             cmd_any, want_erase, accept, start;
  logic [ERR_N-1:0] err_set, err_q;
  logic [7:0]       word;

  assign cmd_any    = cmd_prog | cmd_erase;
  assign want_erase = ~cmd_prog & cmd_erase;
  assign accept     = cmd_any & eng_idle;
  assign start      = accept & ~err_q[ERR_PROT] & ~blk_locked & ~vpp_fault;

  assign err_set[ERR_PROT] = accept & ~err_q[ERR_PROT] & blk_locked;
  assign err_set[ERR_VPP]  = accept & ~err_q[ERR_PROT] & ~blk_locked & vpp_fault;
  assign err_set[ERR_PGM]  = (accept & err_q[ERR_PROT] & ~want_erase)
                           | (eng_finish & ~eng_kind & op_fault);
  assign err_set[ERR_ERS]  = (accept & err_q[ERR_PROT] & want_erase)
                           | (eng_finish & eng_kind & op_fault);

  pe_op_engine #(
    .OP_CYCLES    (OP_CYCLES),
    .GRANT_CYCLES (GRANT_CYCLES)
  ) u_engine (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .start_erase (want_erase),
    .suspend     (cmd_suspend),
    .resume      (cmd_resume),
    .idle        (eng_idle),
    .running     (eng_running),
    .parked      (eng_parked),
    .kind_erase  (eng_kind),
    .finish      (eng_finish)
  );

  pe_err_flags u_flags (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (cmd_clear),
    .set_v (err_set),
    .flags (err_q)
  );

  assign word = {~eng_running,
                 eng_parked & eng_kind,
                 err_q[ERR_ERS],
                 err_q[ERR_PGM],
                 err_q[ERR_VPP],
                 eng_parked & ~eng_kind,
                 err_q[ERR_PROT],
                 1'b0};

  pe_read_port #(.W(8)) u_rdport (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (rd_req_valid),
    .req_ready (rd_req_ready),
    .word_in   (word),
    .out_valid (st_valid),
    .out_ready (st_ready),
    .out_data  (st_data)
  );
endmodule

// File: rtl/pe_status_chk.sv
module pe_status_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_prog,
  input logic       cmd_erase,
  input logic       cmd_clear,
  input logic       blk_locked,
  input logic       rd_req_ready,
  input logic       st_valid,
  input logic       st_ready,
  input logic [7:0] st_data,
  input logic       eng_idle,
  input logic       eng_running,
  input logic [3:0] err_q
);
  p_rsvd_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    st_valid |-> !st_data[0]);

  p_susp_masked_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (st_valid && !st_data[7]) |-> (!st_data[6] && !st_data[2]));

  p_lock_nostart_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((cmd_prog || cmd_erase) && eng_idle && blk_locked) |=> !eng_running);

  p_prot_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (err_q[0] && !cmd_clear) |=> err_q[0]);

  p_clear_all_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_clear && !cmd_prog && !cmd_erase && !eng_running) |=> (err_q == 4'b0));

  p_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (st_valid && !st_ready) |=> (st_valid && $stable(st_data)));

  p_noreq_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (st_valid && !st_ready) |-> !rd_req_ready);
endmodule

bind pe_status_reg pe_status_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cmd_prog     (cmd_prog),
  .cmd_erase    (cmd_erase),
  .cmd_clear    (cmd_clear),
  .blk_locked   (blk_locked),
  .rd_req_ready (rd_req_ready),
  .st_valid     (st_valid),
  .st_ready     (st_ready),
  .st_data      (st_data),
  .eng_idle     (eng_idle),
  .eng_running  (eng_running),
  .err_q        (err_q)
);

// File: tb/pe_status_reg_bench.sv
module pe_status_reg_bench;
  localparam int OP = 8;
  localparam int G  = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_prog = 0, cmd_erase = 0, cmd_suspend = 0, cmd_resume = 0, cmd_clear = 0;
  logic blk_locked = 0, vpp_fault = 0, op_fault = 0;
  logic rd_req_valid = 0, st_ready = 1;
  logic rd_req_ready, st_valid;
  logic [7:0] st_data;

  int n_tests = 0;
  int n_fail  = 0;
  int cycles  = 0;
  bit done    = 0;

  always #5 clk = ~clk;

  pe_status_reg #(.OP_CYCLES(OP), .GRANT_CYCLES(G)) u_pe_status_reg (
    .clk(clk), .rst_n(rst_n),
    .cmd_prog(cmd_prog), .cmd_erase(cmd_erase), .cmd_suspend(cmd_suspend),
    .cmd_resume(cmd_resume), .cmd_clear(cmd_clear),
    .blk_locked(blk_locked), .vpp_fault(vpp_fault), .op_fault(op_fault),
    .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready),
    .st_valid(st_valid), .st_ready(st_ready), .st_data(st_data)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      done = 1;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected<20000", cycles);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic pulse(input bit p, input bit e, input bit s, input bit r, input bit c);
    cmd_prog = p; cmd_erase = e; cmd_suspend = s; cmd_resume = r; cmd_clear = c;
    @(posedge clk);
    @(negedge clk);
    cmd_prog = 0; cmd_erase = 0; cmd_suspend = 0; cmd_resume = 0; cmd_clear = 0;
  endtask

  task automatic read_word(output logic [7:0] w);
    rd_req_valid = 1;
    @(posedge clk);
    @(negedge clk);
    rd_req_valid = 0;
    w = st_data;
  endtask

  // reads every cycle, counts busy words until a ready word arrives
  task automatic count_busy(output int busy, output logic [7:0] last);
    bit masked_ok = 1;
    busy = 0;
    last = 8'h00;
    rd_req_valid = 1;
    for (int k = 0; k < 64; k++) begin
      @(posedge clk);
      @(negedge clk);
      if (st_data[7]) begin
        last = st_data;
        break;
      end
      if (st_data[6] || st_data[2] || st_data[0]) masked_ok = 0;
      busy++;
    end
    rd_req_valid = 0;
    chk(masked_ok, "R6 suspend bits clear while busy", 0, 0);
  endtask

  initial begin
    logic [7:0] w;
    int busy;
    int exp_busy;
    int exp_w;
    bit granted;

    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    chk(!st_valid, "R1 st_valid low after reset", st_valid, 0);
    chk(rd_req_ready, "R13 ready after reset", rd_req_ready, 1);
    read_word(w);
    chk(w == 8'h80, "R1 reset word", w, 8'h80);

    // plain program duration
    pulse(1, 0, 0, 0, 0);
    count_busy(busy, w);
    chk(busy == OP, "R2 program busy cycles", busy, OP);
    chk(w == 8'h80, "R2 word after program", w, 8'h80);

    // suspend sweep over every issue cycle, both kinds
    for (int kind = 0; kind < 2; kind++) begin
      for (int s = 1; s <= OP; s++) begin
        cmd_prog = (kind == 0); cmd_erase = (kind == 1);
        @(posedge clk);
        @(negedge clk);
        cmd_prog = 0; cmd_erase = 0;
        busy = 0;
        w = 8'h00;
        rd_req_valid = 1;
        for (int k = 1; k < 40; k++) begin
          cmd_suspend = (k == s);
          @(posedge clk);
          @(negedge clk);
          cmd_suspend = 0;
          if (st_data[7]) begin
            w = st_data;
            break;
          end
          busy++;
        end
        rd_req_valid = 0;
        granted  = (s + G < OP);
        exp_busy = granted ? s + G : OP;
        exp_w    = granted ? (kind == 1 ? 8'hC0 : 8'h84) : 8'h80;
        if (granted) begin
          chk(busy == exp_busy, "R3 busy before grant", busy, exp_busy);
          chk(w == exp_w, "R3 suspended word", w, exp_w);
          // new command while parked is ignored, even toward a locked block
          blk_locked = 1;
          pulse(kind == 1, kind == 0, 0, 0, 0);
          blk_locked = 0;
          read_word(w);
          chk(w == exp_w, "R12 command ignored while suspended", w, exp_w);
          pulse(0, 0, 0, 1, 0);
          count_busy(busy, w);
          chk(busy == OP - s - G, "R5 remaining cycles after resume", busy, OP - s - G);
          chk(w == 8'h80, "R5 flag cleared after resume", w, 8'h80);
        end else begin
          chk(busy == exp_busy, "R4 full duration when suspend loses", busy, exp_busy);
          chk(w == exp_w, "R4 no suspend flag", w, exp_w);
        end
      end
    end

    // command while running is ignored
    pulse(1, 0, 0, 0, 0);
    blk_locked = 1;
    pulse(0, 1, 0, 0, 0);
    blk_locked = 0;
    count_busy(busy, w);
    chk(busy == OP - 1, "R12 duration unchanged by ignored erase", busy, OP - 1);
    chk(w == 8'h80, "R12 word unchanged by ignored erase", w, 8'h80);

    // abort-condition sweep: leftover protection, locked, voltage fault, kind
    for (int pr = 0; pr < 2; pr++)
      for (int lk = 0; lk < 2; lk++)
        for (int vf = 0; vf < 2; vf++)
          for (int er = 0; er < 2; er++) begin
            pulse(0, 0, 0, 0, 1);
            if (pr == 1) begin
              blk_locked = 1;
              pulse(1, 0, 0, 0, 0);
              blk_locked = 0;
            end
            blk_locked = lk[0];
            vpp_fault  = vf[0];
            pulse(er == 0, er == 1, 0, 0, 0);
            blk_locked = 0;
            vpp_fault  = 0;
            read_word(w);
            if (pr == 1) begin
              exp_w = 8'h82 | (er == 1 ? 8'h20 : 8'h10);
              chk(w == exp_w, "R8 leftover protection fails command", w, exp_w);
              pulse(0, 0, 0, 0, 1);
              read_word(w);
              chk(w == 8'h80, "R11 clear drops protection and error", w, 8'h80);
            end else if (lk == 1) begin
              chk(w == 8'h82, "R7 locked block aborts", w, 8'h82);
            end else if (vf == 1) begin
              chk(w == 8'h88, "R9 voltage fault aborts", w, 8'h88);
            end else begin
              chk(w == 8'h00, "R2 started and busy", w, 8'h00);
              count_busy(busy, w);
              chk(busy == OP - 1, "R2 remaining busy cycles", busy, OP - 1);
              chk(w == 8'h80, "R2 clean completion", w, 8'h80);
            end
          end
    pulse(0, 0, 0, 0, 1);

    // engine fault at completion
    op_fault = 1;
    pulse(1, 0, 0, 0, 0);
    count_busy(busy, w);
    op_fault = 0;
    chk(w == 8'h90, "R10 program error", w, 8'h90);
    pulse(0, 1, 0, 0, 0);
    count_busy(busy, w);
    chk(w == 8'h90, "R11 error survives good erase", w, 8'h90);
    op_fault = 1;
    pulse(0, 1, 0, 0, 0);
    count_busy(busy, w);
    op_fault = 0;
    chk(w == 8'hB0, "R10 erase error added", w, 8'hB0);
    vpp_fault = 1;
    pulse(1, 0, 0, 0, 0);
    vpp_fault = 0;
    read_word(w);
    chk(w == 8'hB8, "R9 voltage flag joins errors", w, 8'hB8);
    pulse(0, 0, 0, 0, 1);
    read_word(w);
    chk(w == 8'h80, "R11 single clear drops all", w, 8'h80);

    // back-pressure on the read port
    st_ready = 0;
    read_word(w);
    chk(st_valid, "R13 response valid", st_valid, 1);
    chk(w == 8'h80, "R13 captured word", w, 8'h80);
    chk(!rd_req_ready, "R13 request blocked", rd_req_ready, 0);
    pulse(1, 0, 0, 0, 0);
    read_word(w);
    chk(st_valid && w == 8'h80, "R13 data held under back-pressure", w, 8'h80);
    st_ready = 1;
    @(posedge clk);
    @(negedge clk);
    chk(!st_valid, "R13 response drained", st_valid, 0);
    repeat (OP + 2) @(posedge clk);
    @(negedge clk);
    read_word(w);
    chk(w == 8'h80, "R2 idle after held read", w, 8'h80);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule